// File: doc/BRIEF.md
# Calibrated Power and Energy Accumulator

This block turns paired voltage and current samples into calibrated instantaneous values, an instantaneous power value and a windowed energy figure. A new pair is presented on `smp_v` and `smp_i` with `smp_valid` high for one clock, once per conversion cycle. Each channel first has a signed offset added and is then multiplied by an unsigned gain. The two corrected values are multiplied to give one power value per pair.

Power values are summed over consecutive, non-overlapping windows of N pairs. N is read from `win_len`. When a window closes, the sum is divided by 4096 by an arithmetic right shift, clipped to 24 bits and published on `energy`, with a one-clock `energy_ready` pulse. All data values are two's complement fractions in which full scale is 1.0. The corrected samples, the power value and the energy value are held on output ports until they are next updated.

Top module: `pwr_energy_acc`

## Requirements
- R1: One clock after a clock with `smp_valid` high, each corrected sample equals floor(((sample + offset) * gain) / 2^22). The offset is added before the gain is applied.
- R2: Corrected samples, power and energy are each clipped to the range -2^23 to 2^23-1.
- R3: Gain is unsigned with 2 integer bits and 22 fraction bits. 0x400000 is unity and 0x800000 doubles the sample. Offset is 24-bit two's complement.
- R4: One clock after a corrected pair is updated, `power` equals floor((v_corr * i_corr) / 2^23), clipped. There is exactly one product per pair.
- R5: On a clock with `smp_valid` low, the corrected samples, power and energy do not change.
- R6: Power values form consecutive windows of N values, where N is `win_len` sampled when a window starts. A value of 0 is treated as 1.
- R7: One clock after the last power value of a window, `energy` equals floor(window sum / 4096), clipped. The sum has no internal overflow for any N below 2^24.
- R8: `energy_ready` is high for exactly the clocks on which a new energy value is published, and for no others.
- R9: A change of `win_len` in the middle of a window does not change that window's length. It applies from the next window.
- R10: While `rst_n` is low, all outputs are zero and the window count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample pair strobe |
| smp_v | input | 24 | Voltage sample, signed |
| smp_i | input | 24 | Current sample, signed |
| cal_v_off | input | 24 | Voltage offset, signed |
| cal_i_off | input | 24 | Current offset, signed |
| cal_v_gain | input | 24 | Voltage gain, unsigned Q2.22 |
| cal_i_gain | input | 24 | Current gain, unsigned Q2.22 |
| win_len | input | 24 | Window length N |
| v_corr | output | 24 | Corrected voltage |
| i_corr | output | 24 | Corrected current |
| power | output | 24 | Instantaneous power |
| energy | output | 24 | Energy of last completed window |
| energy_ready | output | 1 | One-clock pulse when energy is updated |

## Verification
Random in-range samples with unity gain and zero offset show whether the bare product and the window sum are correct. Nonzero offsets paired with gains other than unity separate add-then-scale from scale-then-add. Full-scale samples with a doubling gain, and the product of -1.0 with -1.0, reach every clipping path. Windows of length 0, 1 and 4, gaps in the strobe, and a change of `win_len` inside an open window test the window boundaries and when the new length takes effect.

// File: rtl/pea_pkg.sv
package pea_pkg;
   localparam int unsigned PEA_DATA_W  = 24;
   localparam int unsigned PEA_GAIN_W  = 24;
   localparam int unsigned PEA_GAIN_FR = 22;
   localparam int unsigned PEA_CNT_W   = 24;
   localparam int unsigned PEA_E_SHIFT = 12;

   typedef enum logic [0:0] {
      CH_VOLT = 1'b0,
      CH_CURR = 1'b1
   } pea_chan_e;
endpackage

// File: rtl/pea_cal_chan.sv
module pea_cal_chan #(
   parameter int unsigned DW  = 24,
   parameter int unsigned GW  = 24,
   parameter int unsigned GFR = 22
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic signed [DW-1:0] x,
   input  logic signed [DW-1:0] off,
   input  logic        [GW-1:0] gain,
   output logic signed [DW-1:0] y
);
   localparam int unsigned PW = DW + GW + 2;
   localparam logic signed [PW-1:0] HI = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [PW-1:0] LO = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

   if (GFR >= GW) begin : g_bad_frac
      $error("pea_cal_chan: fraction bits must be fewer than gain bits");
   end

   logic signed [DW:0]   biased;
   logic signed [PW-1:0] scaled;
   logic signed [PW-1:0] shifted;
   logic signed [DW-1:0] clipped;

   always_comb begin
      biased  = $signed({x[DW-1], x}) + $signed({off[DW-1], off});
      scaled  = biased * $signed({1'b0, gain});
      shifted = scaled >>> GFR;
      if (shifted > HI)      clipped = HI[DW-1:0];
      else if (shifted < LO) clipped = LO[DW-1:0];
      else                   clipped = shifted[DW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  y <= '0;
      else if (en) y <= clipped;
   end
endmodule

// File: rtl/pea_mult.sv
module pea_mult #(
   parameter int unsigned DW = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic signed [DW-1:0] a,
   input  logic signed [DW-1:0] b,
   output logic signed [DW-1:0] p,
   output logic                 p_vld
);
   localparam int unsigned PW = 2 * DW;
   localparam logic signed [PW-1:0] HI = {{(DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [PW-1:0] LO = {{(DW+1){1'b1}}, {(DW-1){1'b0}}};

   logic signed [PW-1:0] full;
   logic signed [PW-1:0] shifted;
   logic signed [DW-1:0] clipped;

   always_comb begin
      full    = a * b;
      shifted = full >>> (DW - 1);
      if (shifted > HI)      clipped = HI[DW-1:0];
      else if (shifted < LO) clipped = LO[DW-1:0];
      else                   clipped = shifted[DW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p     <= '0;
         p_vld <= 1'b0;
      end else begin
         p_vld <= en;
         if (en) p <= clipped;
      end
   end
endmodule

// File: rtl/pea_window.sv
module pea_window #(
   parameter int unsigned DW  = 24,
   parameter int unsigned NW  = 24,
   parameter int unsigned ESH = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pw_vld,
   input  logic signed [DW-1:0] pw,
   input  logic        [NW-1:0] n_req,
   output logic signed [DW-1:0] energy,
   output logic                 ready
);
   localparam int unsigned AW = DW + NW + 1;
   localparam logic signed [AW-1:0] HI = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [AW-1:0] LO = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

   if (ESH >= AW) begin : g_bad_shift
      $error("pea_window: shift exceeds accumulator width");
   end

   logic signed [AW-1:0] acc;
   logic        [NW-1:0] cnt;
   logic        [NW-1:0] n_cur;
   logic        [NW-1:0] n_use;
   logic signed [AW-1:0] sum_new;
   logic signed [AW-1:0] scaled;
   logic signed [DW-1:0] clipped;
   logic                 first;
   logic                 last;

   always_comb begin
      first = (cnt == '0);
      if (first) n_use = (n_req == '0) ? NW'(1) : n_req;
      else       n_use = n_cur;
      last    = ({1'b0, cnt} + (NW+1)'(1)) == {1'b0, n_use};
      sum_new = (first ? '0 : acc) + AW'(pw);
      scaled  = sum_new >>> ESH;
      if (scaled > HI)      clipped = HI[DW-1:0];
      else if (scaled < LO) clipped = LO[DW-1:0];
      else                  clipped = scaled[DW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc    <= '0;
         cnt    <= '0;
         n_cur  <= NW'(1);
         energy <= '0;
         ready  <= 1'b0;
      end else begin
         ready <= 1'b0;
         if (pw_vld) begin
            acc   <= sum_new;
            n_cur <= n_use;
            if (last) begin
               cnt    <= '0;
               energy <= clipped;
               ready  <= 1'b1;
            end else begin
               cnt <= cnt + NW'(1);
            end
         end
      end
   end
endmodule

// File: rtl/pwr_energy_acc.sv
module pwr_energy_acc
   import pea_pkg::*;
#(
   parameter int unsigned DW  = PEA_DATA_W,
   parameter int unsigned GW  = PEA_GAIN_W,
   parameter int unsigned GFR = PEA_GAIN_FR,
   parameter int unsigned NW  = PEA_CNT_W,
   parameter int unsigned ESH = PEA_E_SHIFT
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_valid,
   input  logic signed [DW-1:0] smp_v,
   input  logic signed [DW-1:0] smp_i,
   input  logic signed [DW-1:0] cal_v_off,
   input  logic signed [DW-1:0] cal_i_off,
   input  logic        [GW-1:0] cal_v_gain,
   input  logic        [GW-1:0] cal_i_gain,
   input  logic        [NW-1:0] win_len,
   output logic signed [DW-1:0] v_corr,
   output logic signed [DW-1:0] i_corr,
   output logic signed [DW-1:0] power,
   output logic signed [DW-1:0] energy,
   output logic                 energy_ready
);
   localparam int unsigned NCH = 2;

   if (DW < 8 || DW > 31) begin : g_bad_dw
      $error("pwr_energy_acc: data width out of range");
   end
   if (GW < 2) begin : g_bad_gw
      $error("pwr_energy_acc: gain width too small");
   end

   logic signed [DW-1:0] ch_x    [NCH];
   logic signed [DW-1:0] ch_off  [NCH];
   logic        [GW-1:0] ch_gain [NCH];
   logic signed [DW-1:0] ch_y    [NCH];
   logic                 corr_vld;
   logic                 pwr_vld;

   assign ch_x[CH_VOLT]    = smp_v;
   assign ch_x[CH_CURR]    = smp_i;
   assign ch_off[CH_VOLT]  = cal_v_off;
   assign ch_off[CH_CURR]  = cal_i_off;
   assign ch_gain[CH_VOLT] = cal_v_gain;
   assign ch_gain[CH_CURR] = cal_i_gain;

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      pea_cal_chan #(.DW(DW), .GW(GW), .GFR(GFR)) u_cal (
         .clk  (clk),
         .rst_n(rst_n),
         .en   (smp_valid),
         .x    (ch_x[c]),
         .off  (ch_off[c]),
         .gain (ch_gain[c]),
         .y    (ch_y[c])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) corr_vld <= 1'b0;
      else        corr_vld <= smp_valid;
   end

   assign v_corr = ch_y[CH_VOLT];
   assign i_corr = ch_y[CH_CURR];

   pea_mult #(.DW(DW)) u_mult (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (corr_vld),
      .a    (v_corr),
      .b    (i_corr),
      .p    (power),
      .p_vld(pwr_vld)
   );

   pea_window #(.DW(DW), .NW(NW), .ESH(ESH)) u_win (
      .clk   (clk),
      .rst_n (rst_n),
      .pw_vld(pwr_vld),
      .pw    (power),
      .n_req (win_len),
      .energy(energy),
      .ready (energy_ready)
   );
endmodule

// File: rtl/pea_checker.sv
module pea_checker #(
   parameter int unsigned DW = 24
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 smp_valid,
   input logic                 corr_vld,
   input logic                 pwr_vld,
   input logic signed [DW-1:0] v_corr,
   input logic signed [DW-1:0] i_corr,
   input logic signed [DW-1:0] power,
   input logic signed [DW-1:0] energy,
   input logic                 energy_ready
);
   a_r5_corr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !corr_vld |-> ($stable(v_corr) && $stable(i_corr)));

   a_r5_power_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_vld |-> $stable(power));

   a_r4_one_product: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> ##1 pwr_vld);

   a_r8_ready_after_power: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(energy_ready) |-> $past(pwr_vld));

   a_r7_energy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !energy_ready |-> $stable(energy));
endmodule

bind pwr_energy_acc pea_checker #(.DW(DW)) u_pea_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .smp_valid   (smp_valid),
   .corr_vld    (corr_vld),
   .pwr_vld     (pwr_vld),
   .v_corr      (v_corr),
   .i_corr      (i_corr),
   .power       (power),
   .energy      (energy),
   .energy_ready(energy_ready)
);

// File: tb/sim_pwr_energy_acc.sv
module sim_pwr_energy_acc;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_valid = 1'b0;
   logic signed [23:0] smp_v = '0, smp_i = '0;
   logic signed [23:0] cal_v_off = '0, cal_i_off = '0;
   logic [23:0] cal_v_gain = 24'h400000, cal_i_gain = 24'h400000;
   logic [23:0] win_len = 24'd4;
   logic signed [23:0] v_corr, i_corr, power, energy;
   logic energy_ready;

   int n_checks = 0;
   int n_fail = 0;
   int cyc = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_energy_acc u0 (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
      .smp_v(smp_v), .smp_i(smp_i),
      .cal_v_off(cal_v_off), .cal_i_off(cal_i_off),
      .cal_v_gain(cal_v_gain), .cal_i_gain(cal_i_gain),
      .win_len(win_len),
      .v_corr(v_corr), .i_corr(i_corr), .power(power),
      .energy(energy), .energy_ready(energy_ready)
   );

   function automatic longint sat24(input longint x);
      if (x > 64'sd8388607) return 64'sd8388607;
      if (x < -64'sd8388608) return -64'sd8388608;
      return x;
   endfunction

   function automatic longint cal(input longint x, input longint off, input longint g);
      return sat24(((x + off) * g) >>> 22);
   endfunction

   // behavioural reference, stages updated back to front
   longint m_vc, m_ic, m_pw, m_sum, m_en, m_cnt, m_n;
   bit m_cv, m_pv, m_rdy;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_vc = 0; m_ic = 0; m_pw = 0; m_sum = 0; m_en = 0;
         m_cnt = 0; m_n = 1; m_cv = 0; m_pv = 0; m_rdy = 0;
      end else begin
         m_rdy = 0;
         if (m_pv) begin
            if (m_cnt == 0) begin
               m_n = (win_len == 0) ? 1 : longint'(win_len);
               m_sum = m_pw;
            end else begin
               m_sum = m_sum + m_pw;
            end
            if (m_cnt + 1 == m_n) begin
               m_en = sat24(m_sum >>> 12);
               m_rdy = 1;
               m_cnt = 0;
            end else begin
               m_cnt = m_cnt + 1;
            end
         end
         m_pv = m_cv;
         if (m_cv) m_pw = sat24((m_vc * m_ic) >>> 23);
         m_cv = smp_valid;
         if (smp_valid) begin
            m_vc = cal(longint'(smp_v), longint'(cal_v_off), longint'(cal_v_gain));
            m_ic = cal(longint'(smp_i), longint'(cal_i_off), longint'(cal_i_gain));
         end
      end
   end

   task automatic chk(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (rst_n && !finished) begin
         chk("R1/R2/R3 v_corr", longint'(v_corr), m_vc);
         chk("R1/R2/R3 i_corr", longint'(i_corr), m_ic);
         chk("R4/R5 power", longint'(power), m_pw);
         chk("R6/R7/R9 energy", longint'(energy), m_en);
         chk("R8 energy_ready", longint'(energy_ready), longint'(m_rdy));
      end
      if (cyc > 150000 && !finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   task automatic step(input bit vld, input longint v, input longint i);
      @(negedge clk);
      smp_valid <= vld;
      smp_v <= 24'(v);
      smp_i <= 24'(i);
   endtask

   task automatic burst(input int n, input int gap, input bit full_range);
      for (int k = 0; k < n; k++) begin
         longint v, i;
         if (full_range) begin
            v = longint'($signed(24'($urandom)));
            i = longint'($signed(24'($urandom)));
         end else begin
            v = longint'($signed(20'($urandom)));
            i = longint'($signed(20'($urandom)));
         end
         step(1'b1, v, i);
         for (int g = 0; g < gap; g++) step(1'b0, 0, 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 v_corr reset", longint'(v_corr), 0);
      chk("R10 power reset", longint'(power), 0);
      chk("R10 energy reset", longint'(energy), 0);
      chk("R10 ready reset", longint'(energy_ready), 0);
      rst_n <= 1'b1;

      // R1 R4 R6 R7: unity calibration, window of 4
      burst(40, 0, 1'b1);
      // R5: gaps in the strobe
      burst(30, 2, 1'b0);

      // R1 R3: offset applied before gain
      cal_v_off <= 24'sd100000; cal_i_off <= -24'sd250000;
      cal_v_gain <= 24'h300000; cal_i_gain <= 24'h5A0000;
      burst(40, 1, 1'b0);

      // R2: clipping in calibration and product
      cal_v_off <= 24'sd0; cal_i_off <= 24'sd0;
      cal_v_gain <= 24'h800000; cal_i_gain <= 24'h800000;
      step(1'b1, 64'sd8000000, -64'sd8000000);
      step(1'b1, -64'sd8388608, -64'sd8388608);
      step(1'b1, 64'sd8388607, 64'sd8388607);
      step(1'b1, -64'sd6000000, 64'sd100);
      cal_v_gain <= 24'h400000; cal_i_gain <= 24'h400000;
      step(1'b1, -64'sd8388608, -64'sd8388608);
      burst(12, 0, 1'b1);

      // R6: N = 1 and N = 0
      win_len <= 24'd1;
      burst(10, 0, 1'b1);
      win_len <= 24'd0;
      burst(10, 1, 1'b1);

      // R9: change N inside an open window
      win_len <= 24'd5;
      burst(7, 0, 1'b1);
      win_len <= 24'd3;
      burst(20, 0, 1'b1);
      win_len <= 24'd7;
      burst(3, 1, 1'b1);
      win_len <= 24'd2;
      burst(20, 0, 1'b1);

      // R7: long window of full-scale positive power, sum far beyond 24 bits
      win_len <= 24'd600;
      for (int k = 0; k < 1210; k++) step(1'b1, 64'sd8388607, 64'sd8388607);
      for (int k = 0; k < 605; k++) step(1'b1, -64'sd8388608, 64'sd8388607);

      step(1'b0, 0, 0);
      repeat (6) @(negedge clk);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule